// File: doc/BRIEF.md
# Serial Management Frame Master

This block sends one complete management frame to an Ethernet PHY over the two-wire management bus. A host writes a single 32-bit command word that holds the whole frame, from the start code down to the data field. The block then clocks out a preamble of ones and the command word on the data line. The management clock is made by dividing the system clock.

The opcode field selects between a write frame and a read frame. In a write frame every bit of the command word is driven. In a read frame the block drives the bits up to the turnaround and then releases the data line. It shifts in sixteen bits from the PHY on the rising edges of the management clock and puts them in the low half of the same word.

Bit 16 of the word is the completion flag that the host polls. It reads 0 from the moment a frame is accepted and reads 1 once the frame has ended. The host may write again only after that. A write that arrives while a frame is running is dropped.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset the register reads 0x0001_0000, the management clock is low and the data output enable is low.
- R2: A write accepted while idle starts a frame. From the next cycle until the frame ends, bit 16 of the register reads 0.
- R3: Every frame begins with PRE_LEN (default 32) management-clock periods in which the data line is driven to 1 with the output enable high.
- R4: While a frame runs, the management clock has a period of 2*DIV_HALF system cycles, with DIV_HALF cycles high. The data line and its enable change only in the system cycle where the clock falls, or one cycle after a frame is accepted.
- R5: The opcode sits in bits [29:28]. When it is not 10, the 32 bits after the preamble are the written word, most significant bit first, and the output enable stays high.
- R6: When the opcode is 10 (read), the first 14 frame bits (start, opcode, PHY address, register address) are driven from bits [31:18]. The output enable is low for the remaining 18 frame bits (turnaround and data).
- R7: In a read frame, the data input is sampled on the rising clock edge of each of the last 16 frame bits, most significant first. At completion the register reads {written bits [31:17], 1, received 16 bits}.
- R8: After the last bit's falling clock edge, bit 16 reads 1 and the clock and output enable are low. For a non-read frame the register reads {written bits [31:17], 1, written bits [15:0]}.
- R9: A write request made while a frame is running is ignored: the bits on the line and the final register value are those of the frame that is running.
- R10: A frame completes within (PRE_LEN+32)*2*DIV_HALF system cycles of its acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the frame register |
| regWrData | input | 32 | Command word to load |
| regRdData | output | 32 | Frame register contents, with the completion flag and read data |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Management data output value |
| mdioOe | output | 1 | Management data output enable |
| mdioIn | input | 1 | Management data input from the line |

## Verification
Frames with random opcode, addresses and data are mixed with directed ones.

- **Read versus write opcodes.** Mixing them separates the fully driven write path from the read path, which releases the line after 14 bits.
- **Read data patterns.** All ones, all zeros and alternating values show that the sampled bits land in the right positions and are not shifted by one.
- **Opcode 11.** A frame with this opcode confirms that only opcode 10 counts as a read.
- **Mid-frame write.** A write issued in the middle of a frame, with a very different word, would corrupt the line bits or the final register if it were not ignored.

Every frame also has its clock period and its preamble checked.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int FRAME_BITS = 32;
  localparam int FB_W       = $clog2(FRAME_BITS);
  localparam int DATA_W     = 16;
  localparam int DONE_BIT   = 16;
  localparam int OP_HI      = 29;
  localparam int OP_LO      = 28;
  localparam logic [1:0] OP_READ = 2'b10;
  // start + opcode + PHY address + register address
  localparam int DRIVE_BITS = 14;
  // first received bit index inside the frame
  localparam int RX_FIRST   = FRAME_BITS - DATA_W;

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_e;

  typedef struct packed {
    logic            running;
    logic            start;
    logic            sample;
    logic            advance;
    logic            finish;
    logic            inPreamble;
    logic [FB_W-1:0] frameBit;
  } mdioStrobes_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int PRE_LEN  = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  output logic         mdc,
  output mdioStrobes_t strb
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int TOTAL = PRE_LEN + FRAME_BITS;
  localparam int CNT_W = $clog2(TOTAL);
  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] PRE_C    = CNT_W'(PRE_LEN);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_HALF - 1);

  ctrlState_e       state;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             running;
  logic             tick;
  logic             lastBit;

  assign running = (state == ST_RUN);
  assign tick    = running && (divCnt == DIV_LAST);
  assign lastBit = (bitCnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      bitCnt <= '0;
      mdc    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (wrEn) begin
            state  <= ST_RUN;
            divCnt <= '0;
            bitCnt <= '0;
          end
        end
        ST_RUN: begin
          if (tick) begin
            divCnt <= '0;
            mdc    <= ~mdc;
            if (mdc) begin
              if (lastBit) begin
                state  <= ST_IDLE;
                bitCnt <= '0;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.running    = running;
    strb.start      = !running && wrEn;
    strb.sample     = tick && !mdc;
    strb.advance    = tick && mdc && !lastBit;
    strb.finish     = tick && mdc && lastBit;
    strb.inPreamble = (bitCnt < PRE_C);
    strb.frameBit   = FB_W'(bitCnt - PRE_C);
  end

  // R8
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !mdc);

  // R4
  bit_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running) && !$fell(mdc)) |-> $stable(bitCnt));
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [FRAME_BITS-1:0] wrData,
  input  mdioStrobes_t          strb,
  input  logic                  mdioIn,
  output logic [FRAME_BITS-1:0] frameReg,
  output logic                  mdioOut,
  output logic                  mdioOe
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [FB_W-1:0] DRIVE_LIM = FB_W'(DRIVE_BITS);
  localparam logic [FB_W-1:0] RX_START  = FB_W'(RX_FIRST);

  logic [FRAME_BITS-1:0] frameQ;
  logic [FRAME_BITS-1:0] shiftQ;
  logic [DATA_W-1:0]     rxQ;
  logic                  isRead;
  logic                  inRxWindow;

  assign inRxWindow = isRead && !strb.inPreamble && (strb.frameBit >= RX_START);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameQ           <= '0;
      frameQ[DONE_BIT] <= 1'b1;
      shiftQ           <= '0;
      rxQ              <= '0;
      isRead           <= 1'b0;
    end else begin
      if (strb.start) begin
        frameQ           <= wrData;
        frameQ[DONE_BIT] <= 1'b0;
        shiftQ           <= wrData;
        rxQ              <= '0;
        isRead           <= (wrData[OP_HI:OP_LO] == OP_READ);
      end
      if (strb.advance && !strb.inPreamble)
        shiftQ <= {shiftQ[FRAME_BITS-2:0], 1'b0};
      if (strb.sample && inRxWindow)
        rxQ <= {rxQ[DATA_W-2:0], mdioIn};
      if (strb.finish) begin
        frameQ[DONE_BIT] <= 1'b1;
        if (isRead)
          frameQ[DATA_W-1:0] <= rxQ;
      end
    end
  end

  assign frameReg = frameQ;
  assign mdioOut  = strb.inPreamble ? 1'b1 : shiftQ[FRAME_BITS-1];
  assign mdioOe   = strb.running &&
                    (strb.inPreamble || !isRead || (strb.frameBit < DRIVE_LIM));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.running && $past(strb.running)) |-> $stable(frameQ[FRAME_BITS-1:DONE_BIT+1]));
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  timeunit 1ns;
  timeprecision 1ps;

  mdioStrobes_t strb;

  mdio_ctrl #(
    .DIV_HALF(DIV_HALF),
    .PRE_LEN (PRE_LEN)
  ) i_ctrl (
    .clk (clk),
    .rstN(rstN),
    .wrEn(regWrEn),
    .mdc (mdc),
    .strb(strb)
  );

  mdio_datapath i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .wrData  (regWrData),
    .strb    (strb),
    .mdioIn  (mdioIn),
    .frameReg(regRdData),
    .mdioOut (mdioOut),
    .mdioOe  (mdioOe)
  );

  // R2
  busy_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.running |-> !regRdData[DONE_BIT]);

  // R4
  mdio_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.start) && !$fell(mdc)) |-> ($stable(mdioOut) && $stable(mdioOe)));
endmodule

// File: tb/test_mdio_frame_master.sv
module test_mdio_frame_master;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DIV_HALF = 4;
  localparam int PRE_LEN  = 32;
  localparam int NBITS    = PRE_LEN + 32;
  localparam int CLK_NS   = 10;
  localparam longint PERIOD_NS = 2 * DIV_HALF * CLK_NS;
  localparam longint MAX_NS    = NBITS * PERIOD_NS + 2 * CLK_NS;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;  // 100 MHz

  mdio_frame_master #(.DIV_HALF(DIV_HALF), .PRE_LEN(PRE_LEN)) i_mdio_frame_master (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(mdioIn)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic isRd(input logic [31:0] cmd);
    return cmd[29:28] == 2'b10;
  endfunction

  function automatic logic [31:0] expFinal(input logic [31:0] cmd, input logic [15:0] phy);
    return isRd(cmd) ? {cmd[31:17], 1'b1, phy} : {cmd[31:17], 1'b1, cmd[15:0]};
  endfunction

  function automatic logic expOe(input logic [31:0] cmd, input int k);
    return !isRd(cmd) || (k < 14);
  endfunction

  task automatic writeReg(input logic [31:0] d);
    @(negedge clk);
    regWrEn   = 1'b1;
    regWrData = d;
    @(negedge clk);
    regWrEn   = 1'b0;
    regWrData = '0;
  endtask

  task automatic runFrame(input logic [31:0] cmd, input logic [15:0] phy, input logic poke);
    logic [31:0] outBits = '0;
    logic preOk = 1'b1, oeOk = 1'b1, perOk = 1'b1;
    longint t0, lastRise = 0, tDone;
    writeReg(cmd);
    t0 = $time;
    for (int n = 0; n < NBITS; n++) begin
      if (n >= NBITS - 16) mdioIn = phy[15 - (n - (NBITS - 16))];
      else mdioIn = 1'b0;
      @(posedge mdc);
      #1;
      if (n > 0 && ($time - lastRise) != PERIOD_NS) perOk = 1'b0;
      lastRise = $time;
      if (n < PRE_LEN) begin
        if (!(mdioOut && mdioOe)) preOk = 1'b0;
      end else begin
        outBits[31 - (n - PRE_LEN)] = mdioOut;
        if (mdioOe !== expOe(cmd, n - PRE_LEN)) oeOk = 1'b0;
      end
      if (poke && n == 10) begin
        // R2: flag low mid-frame
        check(regRdData[16] == 1'b0, "R2", {31'b0, regRdData[16]}, 32'h0);
        // R9: a write during the frame must be ignored
        writeReg(~cmd);
      end
      @(negedge mdc);
    end
    @(negedge clk);
    tDone = $time - t0;
    check(preOk, "R3", {31'b0, preOk}, 32'h1);
    check(perOk, "R4", {31'b0, perOk}, 32'h1);
    if (isRd(cmd))
      check(outBits[31:18] == cmd[31:18], "R6", {18'b0, outBits[31:18]}, {18'b0, cmd[31:18]});
    else
      check(outBits == cmd, poke ? "R9" : "R5", outBits, cmd);
    check(oeOk, isRd(cmd) ? "R6" : "R5", {31'b0, oeOk}, 32'h1);
    check(regRdData == expFinal(cmd, phy), isRd(cmd) ? "R7" : "R8",
          regRdData, expFinal(cmd, phy));
    check(!mdc && !mdioOe, "R8", {30'b0, mdc, mdioOe}, 32'h0);
    check(tDone <= MAX_NS, "R10", 32'(tDone), 32'(MAX_NS));
  endtask

  function automatic logic [31:0] mkCmd(input logic rd, input logic [4:0] phyA,
                                        input logic [4:0] regA, input logic [15:0] d);
    return rd ? (32'h6002_0000 | {4'b0, phyA, regA, 18'b0})
              : (32'h5002_0000 | {4'b0, phyA, regA, 2'b0, d});
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7151));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(regRdData == 32'h0001_0000, "R1", regRdData, 32'h0001_0000);
    check(!mdc && !mdioOe, "R1", {30'b0, mdc, mdioOe}, 32'h0);

    // directed corners
    runFrame(mkCmd(1'b0, 5'd0, 5'd0, 16'h1000), 16'h0, 1'b0);
    runFrame(mkCmd(1'b1, 5'h1f, 5'h1f, 16'h0), 16'hFFFF, 1'b0);
    runFrame(mkCmd(1'b1, 5'h00, 5'h01, 16'h0), 16'h0000, 1'b0);
    runFrame(mkCmd(1'b1, 5'h0a, 5'h15, 16'h0), 16'hA5C3, 1'b0);
    runFrame(32'h7002_ABCD, 16'h1234, 1'b0);             // opcode 11 is driven
    runFrame(mkCmd(1'b0, 5'h11, 5'h02, 16'hFFFF), 16'h0, 1'b1);
    runFrame(mkCmd(1'b1, 5'h03, 5'h04, 16'h0), 16'h8001, 1'b1);

    // random frames
    for (int i = 0; i < 8; i++) begin
      logic rd = 1'($urandom);
      runFrame(mkCmd(rd, 5'($urandom), 5'($urandom), 16'($urandom)), 16'($urandom), 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule